// File: doc/BRIEF.md
# JTAG Scan Master

This block is the host side of a JTAG link. It turns one accepted command into a full walk of the TAP state diagram on the attached chain: it toggles TCK from the system clock through a half-period divider, drives TMS and TDI, and samples TDO. Three commands are supported. A TAP reset leaves every target in Run-Test/Idle with its default instruction loaded. An instruction scan shifts `IR_LEN` bits. A data scan shifts between 1 and `DR_MAX` bits. Shift data arrives as one parallel word. The bits read back from TDO leave as one parallel word, marked by a single-clock done pulse.

Every scan starts and ends in Run-Test/Idle. The final shifted bit is always sent in the same TCK cycle that raises TMS. Because of this, the Exit1 transition carries the last bit, and no extra bit rolls through the target register.

The sequencer states, each of which is one emitted TCK cycle except IDLE and DONE, are:

| State | Meaning |
|---|---|
| IDLE | No TCK activity. |
| RESET | TMS=1 cycles. |
| TLR | One TMS=0 cycle out of Test-Logic-Reset. |
| RTI | TMS=1 into Select-DR. |
| SEL_DR | TMS=1 for an instruction scan, 0 for a data scan. |
| SEL_IR | TMS=0. |
| CAPTURE | TMS=0 into Shift. |
| SHIFT | One per bit; TMS=1 only on the last bit. |
| EXIT1 | TMS=1. |
| UPDATE | TMS=0 back to Run-Test/Idle. |
| DONE | Result strobe. |

The transitions are:

- IDLE→RESET on a reset command.
- IDLE→RTI on a scan command.
- RESET→TLR after `RESET_CYC` cycles.
- TLR→DONE.
- RTI→SEL_DR.
- SEL_DR→SEL_IR for an instruction scan, SEL_DR→CAPTURE for a data scan.
- SEL_IR→CAPTURE.
- CAPTURE→SHIFT.
- SHIFT→EXIT1 after the last bit.
- EXIT1→UPDATE.
- UPDATE→DONE.
- DONE→IDLE.

Top module: `jsm_top`

## Requirements
- R1: TMS and TDI change only at the clock edge where TCK falls, or while no TCK cycle is in progress, so they are steady across every rising TCK edge. TDO is captured at the system clock edge where TCK rises, which is after the target's falling-edge update.
- R2: `cmd_op` = 2'b01 starts an instruction scan. It emits IR_LEN+6 TCK cycles with the TMS pattern 1,1,0,0, then IR_LEN shift cycles (TMS 0 except the last one at 1), then 1,0, and it ends with the chain in Run-Test/Idle.
- R3: `cmd_op` = 2'b10 or 2'b11 starts a data scan of M bits. It emits M+5 TCK cycles with the TMS pattern 1,0,0, then M shift cycles (TMS 0 except the last one at 1), then 1,0, and it ends in Run-Test/Idle.
- R4: `cmd_op` = 2'b00 starts a TAP reset: RESET_CYC (default 5) cycles with TMS=1, then one cycle with TMS=0. A 32-bit data scan issued straight after it, with no instruction scan in between, returns the target's IDCODE.
- R5: Exactly the requested number of bits enter the target register, sent from `cmd_data` bit 0 upward. After an instruction scan with the low IR_LEN bits of `cmd_data`, the target executes that opcode, and a 2-bit bypass scan returns the first TDI bit delayed by one position.
- R6: `rsp_data` bit i holds the TDO value of the i-th shift cycle, with bit 0 first out. Bits at and above the scan length read 0, and a reset returns all zeros.
- R7: Each TCK half-period lasts HALF_DIV system clocks, with a floor of 2. TCK rests at TCK_IDLE (default 1) whenever no command is running. `rsp_done` rises 1 + 2·HALF_DIV·C clocks after the acceptance edge, where C is the TCK cycle count of the command.
- R8: `cmd_ready` is high only when idle, and a command is accepted on a clock where both `cmd_valid` and `cmd_ready` are high. `busy` is high from the acceptance edge through the `rsp_done` clock. A command offered while busy is dropped and starts nothing.
- R9: A data-scan length of 0 is treated as 1. A length above DR_MAX is treated as DR_MAX.
- R10: Out of reset: `tck` = TCK_IDLE, `tms` = 0, `tdi` = 0, `busy` = 0, `cmd_ready` = 1, `rsp_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; command taken when both high |
| cmd_op | input | 2 | 00 reset, 01 instruction scan, 10/11 data scan |
| cmd_len | input | $clog2(DR_MAX+1) | Data-scan length in bits |
| cmd_data | input | DR_MAX | Bits to shift, bit 0 first |
| rsp_done | output | 1 | One-clock completion strobe |
| rsp_data | output | DR_MAX | Captured TDO bits, bit 0 first |
| busy | output | 1 | Command in progress |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to chain |
| tdo | input | 1 | Test data from chain |

## Verification
Every result is due at a cycle fixed by the command alone. `rsp_done` and `rsp_data` appear 1 + 2·HALF_DIV·C clocks after the acceptance edge, with C equal to 6 for a reset, IR_LEN+6 for an instruction scan and M+5 for a data scan. The bench counts falling system-clock edges from acceptance, compares the count against that formula, and checks `busy` at each step. It reads the data and the idle TCK level on the done clock, and it checks the state of a behavioural target model right after. Dropped commands are checked by watching `busy` and `tck` for several clocks after the done strobe.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
    typedef enum logic [1:0] {
        OP_RESET  = 2'b00,
        OP_IR     = 2'b01,
        OP_DR     = 2'b10,
        OP_DR_ALT = 2'b11
    } jsm_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RESET, ST_TLR, ST_RTI, ST_SEL_DR, ST_SEL_IR,
        ST_CAPTURE, ST_SHIFT, ST_EXIT1, ST_UPDATE, ST_DONE
    } jsm_state_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_LOW, PH_HIGH
    } jsm_phase_e;
endpackage

// File: rtl/jsm_tck_gen.sv
module jsm_tck_gen #(
    parameter int HALF_DIV = 2,
    parameter bit TCK_IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic keep,
    output logic tck,
    output logic rise,
    output logic cyc_end
);
    import jsm_pkg::*;

    localparam int HD = (HALF_DIV < 2) ? 2 : HALF_DIV;
    localparam int CW = $clog2(HD);

    jsm_phase_e    phase_q;
    logic [CW-1:0] cnt_q;
    logic          half_end;

    assign half_end = (cnt_q == CW'(HD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (run) phase_q <= PH_LOW;
                end
                PH_LOW: begin
                    cnt_q <= half_end ? '0 : cnt_q + 1'b1;
                    if (half_end) phase_q <= PH_HIGH;
                end
                PH_HIGH: begin
                    cnt_q <= half_end ? '0 : cnt_q + 1'b1;
                    if (half_end) phase_q <= keep ? PH_LOW : PH_IDLE;
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign tck     = (phase_q == PH_HIGH) || ((phase_q == PH_IDLE) && TCK_IDLE);
    assign rise    = (phase_q == PH_LOW)  && half_end;
    assign cyc_end = (phase_q == PH_HIGH) && half_end;
endmodule

// File: rtl/jsm_shifter.sv
module jsm_shifter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic [IW-1:0]    load_last,
    input  logic             advance,
    input  logic             sample,
    input  logic             tdo,
    output logic             tdi,
    output logic             last,
    output logic [WIDTH-1:0] rx_data
);
    localparam int IW = (WIDTH > 2) ? $clog2(WIDTH) : 1;

    logic [WIDTH-1:0] tx_q, rx_q;
    logic [IW-1:0]    idx_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (load) begin
            tx_q   <= load_data;
            rx_q   <= '0;
            idx_q  <= '0;
            last_q <= load_last;
        end else begin
            if (sample)  rx_q[idx_q] <= tdo;
            if (advance) idx_q <= idx_q + 1'b1;
        end
    end

    assign tdi     = tx_q[idx_q];
    assign last    = (idx_q == last_q);
    assign rx_data = rx_q;

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= last_q);                                           // R9
endmodule

// File: rtl/jsm_top.sv
module jsm_top #(
    parameter int IR_LEN    = 4,
    parameter int DR_MAX    = 32,
    parameter int HALF_DIV  = 2,
    parameter bit TCK_IDLE  = 1'b1,
    parameter int RESET_CYC = 5,
    localparam int LENW     = $clog2(DR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [LENW-1:0]   cmd_len,
    input  logic [DR_MAX-1:0] cmd_data,
    output logic              rsp_done,
    output logic [DR_MAX-1:0] rsp_data,
    output logic              busy,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);
    import jsm_pkg::*;

    localparam int IW  = (DR_MAX > 2) ? $clog2(DR_MAX) : 1;
    localparam int RCW = (RESET_CYC > 2) ? $clog2(RESET_CYC) : 1;

    jsm_state_e     state_q, state_d;
    logic           is_ir_q;
    logic [RCW-1:0] rst_cnt_q;
    logic [IW-1:0]  len_last;
    logic           accept, run, keep, rise, cyc_end;
    logic           sh_tdi, sh_last, in_shift;
    jsm_op_e        op;

    assign op     = jsm_op_e'(cmd_op);
    assign accept = cmd_valid && (state_q == ST_IDLE);

    always_comb begin
        if (op == OP_IR)                    len_last = IW'(IR_LEN - 1);
        else if (cmd_len == '0)             len_last = '0;
        else if (cmd_len > LENW'(DR_MAX))   len_last = IW'(DR_MAX - 1);
        else                                len_last = IW'(cmd_len - 1'b1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            is_ir_q   <= 1'b0;
            rst_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                is_ir_q   <= (op == OP_IR);
                rst_cnt_q <= '0;
            end else if ((state_q == ST_RESET) && cyc_end) begin
                rst_cnt_q <= rst_cnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd_valid) state_d = (op == OP_RESET) ? ST_RESET : ST_RTI;
            ST_RESET:   if (cyc_end && (rst_cnt_q == RCW'(RESET_CYC - 1))) state_d = ST_TLR;
            ST_TLR:     if (cyc_end) state_d = ST_DONE;
            ST_RTI:     if (cyc_end) state_d = ST_SEL_DR;
            ST_SEL_DR:  if (cyc_end) state_d = is_ir_q ? ST_SEL_IR : ST_CAPTURE;
            ST_SEL_IR:  if (cyc_end) state_d = ST_CAPTURE;
            ST_CAPTURE: if (cyc_end) state_d = ST_SHIFT;
            ST_SHIFT:   if (cyc_end && sh_last) state_d = ST_EXIT1;
            ST_EXIT1:   if (cyc_end) state_d = ST_UPDATE;
            ST_UPDATE:  if (cyc_end) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tms = 1'b0;
        unique case (state_q)
            ST_RESET:  tms = 1'b1;
            ST_RTI:    tms = 1'b1;
            ST_SEL_DR: tms = is_ir_q;
            ST_SHIFT:  tms = sh_last;
            ST_EXIT1:  tms = 1'b1;
            default:   tms = 1'b0;
        endcase
        in_shift  = (state_q == ST_SHIFT);
        tdi       = in_shift ? sh_tdi : 1'b0;
        run       = (state_q != ST_IDLE) && (state_q != ST_DONE);
        keep      = (state_d != ST_IDLE) && (state_d != ST_DONE);
        busy      = (state_q != ST_IDLE);
        cmd_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_DONE);
    end

    jsm_tck_gen #(.HALF_DIV(HALF_DIV), .TCK_IDLE(TCK_IDLE)) u_tck (
        .clk(clk), .rst_n(rst_n), .run(run), .keep(keep),
        .tck(tck), .rise(rise), .cyc_end(cyc_end)
    );

    jsm_shifter #(.WIDTH(DR_MAX)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_data(cmd_data),
        .load_last(len_last), .advance(in_shift && cyc_end && !sh_last),
        .sample(in_shift && rise), .tdo(tdo), .tdi(sh_tdi),
        .last(sh_last), .rx_data(rsp_data)
    );

    AST_TMS_TDI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> ($stable(tms) && $stable(tdi)));             // R1
    AST_DONE_AT_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (tck == TCK_IDLE));                            // R7
    AST_TCK_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tck != TCK_IDLE) |-> busy);                                // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);                         // R8
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rsp_done));                           // R8
endmodule

// File: tb/tb_jsm_top.sv
module tb_jsm_top;
    localparam int IR_LEN = 4, DR_MAX = 32, HALF_DIV = 2, RESET_CYC = 5;
    localparam bit TCK_IDLE = 1'b1;
    localparam int LENW = $clog2(DR_MAX + 1);
    localparam logic [3:0]  ID_OP  = 4'b1110;
    localparam logic [31:0] ID_VAL = 32'h1A5C_E03F;
    localparam int T_TLR=0, T_RTI=1, T_SDR=2, T_CDR=3, T_SHD=4, T_E1D=5, T_PDR=6, T_E2D=7,
                   T_UDR=8, T_SIR=9, T_CIR=10, T_SHI=11, T_E1I=12, T_PIR=13, T_E2I=14, T_UIR=15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [LENW-1:0] cmd_len = '0;
    logic [DR_MAX-1:0] cmd_data = '0;
    logic cmd_ready, rsp_done, busy, tck, tms, tdi, tdo;
    logic [DR_MAX-1:0] rsp_data;
    int checks = 0, fails = 0;
    logic [3:0] exp_ir = ID_OP;

    always #2 clk = ~clk;

    jsm_top #(.IR_LEN(IR_LEN), .DR_MAX(DR_MAX), .HALF_DIV(HALF_DIV),
              .TCK_IDLE(TCK_IDLE), .RESET_CYC(RESET_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .busy(busy),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

    // behavioural TAP target
    int t_state;
    logic [3:0] t_ir, t_irsr;
    logic [31:0] t_dr;
    logic t_byp;

    function automatic int tap_next(int s, logic m);
        case (s)
            T_TLR: return m ? T_TLR : T_RTI;   T_RTI: return m ? T_SDR : T_RTI;
            T_SDR: return m ? T_SIR : T_CDR;   T_CDR: return m ? T_E1D : T_SHD;
            T_SHD: return m ? T_E1D : T_SHD;   T_E1D: return m ? T_UDR : T_PDR;
            T_PDR: return m ? T_E2D : T_PDR;   T_E2D: return m ? T_UDR : T_SHD;
            T_UDR: return m ? T_SDR : T_RTI;   T_SIR: return m ? T_TLR : T_CIR;
            T_CIR: return m ? T_E1I : T_SHI;   T_SHI: return m ? T_E1I : T_SHI;
            T_E1I: return m ? T_UIR : T_PIR;   T_PIR: return m ? T_E2I : T_PIR;
            T_E2I: return m ? T_UIR : T_SHI;   default: return m ? T_SDR : T_RTI;
        endcase
    endfunction

    always @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            t_state <= T_TLR; t_ir <= ID_OP; t_irsr <= '0; t_dr <= '0; t_byp <= 1'b0;
        end else begin
            case (t_state)
                T_TLR: t_ir <= ID_OP;
                T_CIR: t_irsr <= 4'b0001;
                T_SHI: t_irsr <= {tdi, t_irsr[3:1]};
                T_UIR: t_ir <= t_irsr;
                T_CDR: if (t_ir == ID_OP) t_dr <= ID_VAL; else t_byp <= 1'b0;
                T_SHD: if (t_ir == ID_OP) t_dr <= {tdi, t_dr[31:1]}; else t_byp <= tdi;
                default: ;
            endcase
            t_state <= tap_next(t_state, tms);
        end
    end

    always @(negedge tck or negedge rst_n) begin
        if (!rst_n) tdo <= 1'b0;
        else if (t_state == T_SHI) tdo <= t_irsr[0];
        else if (t_state == T_SHD) tdo <= (t_ir == ID_OP) ? t_dr[0] : t_byp;
        else tdo <= 1'b0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int eff_len(logic [LENW-1:0] n);
        if (n == 0) return 1;
        if (n > DR_MAX) return DR_MAX;
        return int'(n);
    endfunction

    function automatic logic [31:0] len_mask(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    // expected result and TCK cycle count from the requirements
    function automatic logic [31:0] exp_result(logic [1:0] op, logic [3:0] ir, int n,
                                               logic [31:0] d);
        if (op == 2'b00) return '0;
        if (op == 2'b01) return 32'h1;                      // captured 0001
        if (ir == ID_OP) return ID_VAL & len_mask(n);
        return {d[30:0], 1'b0} & len_mask(n);              // bypass delays TDI
    endfunction

    function automatic int exp_cycles(logic [1:0] op, int n);
        if (op == 2'b00) return RESET_CYC + 1;
        if (op == 2'b01) return IR_LEN + 6;
        return n + 5;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [LENW-1:0] len,
                          input logic [31:0] d, input bit poke_busy);
        int n, lat, busy_bad;
        logic [31:0] er;
        string tag;
        n  = eff_len(len);
        er = exp_result(op, exp_ir, n, d);
        tag = (op == 2'b00) ? "R4" : (op == 2'b01) ? "R2" : "R3";
        @(negedge clk);
        chk("R8 ready before command", {31'd0, cmd_ready}, 32'd1);
        cmd_valid = 1'b1; cmd_op = op; cmd_len = len; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0; busy_bad = 0;
        if (poke_busy) begin
            cmd_valid = 1'b1; cmd_op = 2'b00; cmd_data = ~d;
        end
        while (!rsp_done && lat < 5000) begin
            if (!busy) busy_bad++;
            if (poke_busy && lat == 3) cmd_valid = 1'b0;
            @(negedge clk);
            lat++;
        end
        cmd_valid = 1'b0;
        chk({tag, "/R7 done latency"}, lat, 1 + 2 * HALF_DIV * exp_cycles(op, n));
        chk("R8 busy held until done", {31'd0, busy} + busy_bad, 32'd1);
        chk("R5/R6 result data", rsp_data, er);
        chk("R7 idle TCK at done", {31'd0, tck}, {31'd0, TCK_IDLE});
        @(negedge clk);
        chk({tag, " target in Run-Test/Idle"}, t_state, T_RTI);
        if (op == 2'b00) exp_ir = ID_OP;
        else if (op == 2'b01) exp_ir = d[3:0];
        chk("R5 target opcode", {28'd0, t_ir}, {28'd0, exp_ir});
        if (poke_busy) begin
            repeat (4) @(negedge clk);
            chk("R8 command offered while busy dropped", {30'd0, busy, tck},
                {30'd0, 1'b0, TCK_IDLE});
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240419));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset outputs", {26'd0, tck, tms, tdi, busy, cmd_ready, rsp_done},
            {26'd0, TCK_IDLE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 idle after reset release", {30'd0, busy, tck}, {30'd0, 1'b0, TCK_IDLE});

        run_op(2'b00, '0, 32'h0, 1'b0);                        // R4 reset
        run_op(2'b10, LENW'(32), 32'h0, 1'b0);                 // R4 IDCODE read
        run_op(2'b11, LENW'(0), 32'h0, 1'b0);                  // R9 len 0 -> 1
        run_op(2'b10, LENW'(40), 32'h5, 1'b0);                 // R9 len 40 -> 32
        run_op(2'b01, '0, 32'hFFFF_FFFF, 1'b0);                // R2 select bypass
        run_op(2'b10, LENW'(2), 32'h1, 1'b0);                  // R5 bypass delay
        run_op(2'b10, LENW'(1), 32'h1, 1'b0);                  // R6 1-bit bypass
        run_op(2'b01, '0, {28'h0, ID_OP}, 1'b1);               // R2 + R8 poke
        run_op(2'b10, LENW'(32), 32'hDEAD_BEEF, 1'b0);         // R5 IDCODE again
        run_op(2'b10, LENW'(7), 32'h3, 1'b1);                  // R3 + R8 poke

        for (int i = 0; i < 250; i++) begin
            int sel;
            logic [1:0] op;
            logic [31:0] d;
            sel = int'($urandom_range(0, 9));
            d = $urandom();
            op = (sel == 0) ? 2'b00 : (sel < 4) ? 2'b01 : ((sel & 1) != 0) ? 2'b11 : 2'b10;
            if (op == 2'b01 && $urandom_range(0, 2) == 0) d[3:0] = ID_OP;
            run_op(op, LENW'($urandom_range(0, DR_MAX)), d, (i % 17) == 5);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule